// File: doc/BRIEF.md
# User-level address monitor unit

This unit arms a store-watching monitor when a user-level arm request arrives. The request carries an effective address, an address-size mode, the selected segment's base and limit, and flags that say whether the segment is the stack segment or null. It also carries the feature-enable bit and an in-transaction indication. The unit checks the request for faults in the same cycle. If the request is clean, it forms the linear address, aligns it down to a power-of-two range, and enters the armed state. A faulting request leaves the monitor untouched. It reports one fault code on a single-cycle fault-valid output.

While the unit is armed, it watches a stream of store transactions. A write-back store that falls inside the monitored range moves the unit to the triggered state. Wait logic outside the block reads the armed and triggered outputs, and it returns the unit to idle with a consume pulse. A separate output answers a legacy wait. It reports that the legacy wait must not sleep whenever a successful user-level arm is more recent than the last legacy monitor arm. The range size is a parameter, and a constant output reports it so that software can query it.

Top module: `umon_unit`

## Requirements
- R1: A fault-free arm request moves the unit to armed one cycle later (armed_o=1, triggered_o=0). This holds from any state, and the new range replaces the old one.
- R2: The monitored range is the linear address aligned down to 2^LINE_LOG2 bytes. A store matches when its address bits above LINE_LOG2 equal those of the range. range_bytes_o reports 2^LINE_LOG2 (64 by default).
- R3: While armed, a valid store with memory type 3'd6 (write-back) inside the range sets triggered_o=1 and armed_o=0 one cycle later. In idle, such a store has no effect.
- R4: A store of any other memory type, or a store outside the range, leaves the state unchanged.
- R5: An arm request with feat_en_i=0 reports fault code 1 (undefined opcode). This fault has the highest priority.
- R6: An arm request with in_txn_i=1 and the feature enabled reports code 4 (transactional abort) and does not arm.
- R7: In mode 3 (64-bit), linear address = seg_base_i + eff_addr_i. If bits 63:47 of the linear address are not all equal, the unit reports code 3 (stack fault) when seg_is_ss_i=1 and code 2 (general protection) otherwise.
- R8: In mode 0 (real), the effective address is the low 32 bits of eff_addr_i. A value above 0xFFFF reports code 3 for the stack segment and code 2 otherwise.
- R9: In modes 1 (protected, 16-bit addresses) and 2 (protected, 32-bit addresses), seg_null_i=1 reports code 2. Otherwise an effective address above seg_limit_i reports code 3 for the stack segment and code 2 otherwise.
- R10: The effective address uses only the low 16, 32 or 64 bits for modes 1, 2 and 3. In modes 0 to 2, the linear address is the 32-bit sum of the low base bits and the effective address.
- R11: fault_valid_o pulses for one cycle after a faulting request, and armed_o and triggered_o stay as they were. fault_code_o is 0 whenever fault_valid_o is 0.
- R12: wait_consume_i returns the unit to idle next cycle. An arm request in the same cycle wins over a consume or a store.
- R13: legacy_nosleep_o is set by a successful user arm and cleared by legacy_arm_i. A faulting arm does not change it, and a user arm in the same cycle as a legacy arm leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_req_i | input | 1 | User-level arm request |
| addr_mode_i | input | 2 | 0 real, 1 protected/16-bit, 2 protected/32-bit, 3 64-bit |
| eff_addr_i | input | ADDR_W | Effective address from the source register |
| seg_base_i | input | ADDR_W | Base of the selected segment |
| seg_limit_i | input | 32 | Limit of the selected segment |
| seg_is_ss_i | input | 1 | Selected segment is the stack segment |
| seg_null_i | input | 1 | Selected segment holds a null selector |
| feat_en_i | input | 1 | Feature enable |
| in_txn_i | input | 1 | Request issued inside a transactional region |
| st_valid_i | input | 1 | Store transaction valid |
| st_addr_i | input | ADDR_W | Store linear address |
| st_mtype_i | input | 3 | Store memory type, 3'd6 = write-back |
| wait_consume_i | input | 1 | Wait logic consumes the monitor state |
| legacy_arm_i | input | 1 | Legacy monitor was armed |
| armed_o | output | 1 | Monitor armed and not yet triggered |
| triggered_o | output | 1 | Monitored range was written |
| fault_valid_o | output | 1 | One-cycle fault report |
| fault_code_o | output | 3 | 0 none, 1 undefined opcode, 2 general protection, 3 stack, 4 transactional abort |
| legacy_nosleep_o | output | 1 | Legacy wait must not enter an optimized state |
| range_bytes_o | output | LINE_LOG2+1 | Monitored range size in bytes |

## Verification
A stale or wrongly aligned range tag shows as a missed trigger, or as a trigger from a neighbouring range. The first write-back store just beyond either edge of the range exposes it on triggered_o one cycle after the store. A wrong fault priority or wrong segment selection shows in fault_code_o in the cycle after the request. If a faulting request corrupts state, the change appears on armed_o in that same cycle. A wrong legacy ordering flag shows on legacy_nosleep_o one cycle after the arm or legacy event that should have changed it.

// File: rtl/umon_pkg.sv
package umon_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_P16  = 2'd1,
    MODE_P32  = 2'd2,
    MODE_L64  = 2'd3
  } amode_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_GP   = 3'd2,
    FLT_SS   = 3'd3,
    FLT_TXA  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    MON_IDLE  = 2'd0,
    MON_ARMED = 2'd1,
    MON_TRIG  = 2'd2
  } mon_state_e;

  localparam logic [2:0] MTYPE_WB = 3'd6;
endpackage

// File: rtl/umon_req_check.sv
module umon_req_check
  import umon_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48,
  parameter int LIM_W   = 32
) (
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [ADDR_W-1:0] seg_base_i,
  input  logic [LIM_W-1:0]  seg_limit_i,
  input  logic              seg_is_ss_i,
  input  logic              seg_null_i,
  input  logic              feat_en_i,
  input  logic              in_txn_i,
  output fault_e            fault_o,
  output logic [ADDR_W-1:0] lin_o
);
  localparam int HI_W = ADDR_W - VA_BITS + 1;

  logic [ADDR_W-1:0] ea_w;
  logic [31:0]       sum32;
  logic [HI_W-1:0]   hi_bits;
  logic              canon_ok;
  fault_e            seg_flt;

  always_comb begin
    unique case (amode_e'(mode_i))
      MODE_P16: ea_w = {{(ADDR_W-16){1'b0}}, ea_i[15:0]};
      MODE_L64: ea_w = ea_i;
      default:  ea_w = {{(ADDR_W-32){1'b0}}, ea_i[31:0]};
    endcase
  end

  assign sum32    = seg_base_i[31:0] + ea_w[31:0];
  assign lin_o    = (amode_e'(mode_i) == MODE_L64) ? (seg_base_i + ea_w)
                                                   : {{(ADDR_W-32){1'b0}}, sum32};
  assign hi_bits  = lin_o[ADDR_W-1:VA_BITS-1];
  assign canon_ok = (&hi_bits) | ~(|hi_bits);
  assign seg_flt  = seg_is_ss_i ? FLT_SS : FLT_GP;

  // priority: feature off, transaction, then mode-specific segment checks
  always_comb begin
    fault_o = FLT_NONE;
    if (!feat_en_i) begin
      fault_o = FLT_UD;
    end else if (in_txn_i) begin
      fault_o = FLT_TXA;
    end else begin
      unique case (amode_e'(mode_i))
        MODE_REAL: if (ea_w > ADDR_W'(16'hFFFF)) fault_o = seg_flt;
        MODE_P16, MODE_P32: begin
          if (seg_null_i)                          fault_o = FLT_GP;
          else if (ea_w > ADDR_W'(seg_limit_i))    fault_o = seg_flt;
        end
        MODE_L64: if (!canon_ok) fault_o = seg_flt;
        default: fault_o = FLT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/umon_range.sv
module umon_range #(
  parameter int ADDR_W    = 64,
  parameter int LINE_LOG2 = 6,
  localparam int TAG_W    = ADDR_W - LINE_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] lin_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic              hit_o
);
  logic [TAG_W-1:0] tag_q;
  logic             unused_lo;

  // offset bits inside the range never take part in matching
  assign unused_lo = ^{lin_i[LINE_LOG2-1:0], st_addr_i[LINE_LOG2-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tag_q <= '0;
    else if (load_i) tag_q <= lin_i[ADDR_W-1:LINE_LOG2];
  end

  assign tag_o = tag_q;
  assign hit_o = (st_addr_i[ADDR_W-1:LINE_LOG2] == tag_q);
endmodule

// File: rtl/umon_fsm.sv
module umon_fsm
  import umon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_ok_i,
  input  logic       st_hit_i,
  input  logic       consume_i,
  input  logic       legacy_arm_i,
  output mon_state_e state_o,
  output logic       legacy_nosleep_o
);
  mon_state_e state_q, state_d;
  logic       leg_q;

  always_comb begin
    state_d = state_q;
    if (arm_ok_i)                                state_d = MON_ARMED;
    else if (consume_i)                          state_d = MON_IDLE;
    else if (state_q == MON_ARMED && st_hit_i)   state_d = MON_TRIG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_IDLE;
      leg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      // user arm counts as the later event when both arrive together
      if (arm_ok_i)          leg_q <= 1'b1;
      else if (legacy_arm_i) leg_q <= 1'b0;
    end
  end

  assign state_o          = state_q;
  assign legacy_nosleep_o = leg_q;
endmodule

// File: rtl/umon_unit.sv
module umon_unit
  import umon_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VA_BITS   = 48,
  parameter int LINE_LOG2 = 6,
  localparam int TAG_W    = ADDR_W - LINE_LOG2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 arm_req_i,
  input  logic [1:0]           addr_mode_i,
  input  logic [ADDR_W-1:0]    eff_addr_i,
  input  logic [ADDR_W-1:0]    seg_base_i,
  input  logic [31:0]          seg_limit_i,
  input  logic                 seg_is_ss_i,
  input  logic                 seg_null_i,
  input  logic                 feat_en_i,
  input  logic                 in_txn_i,
  input  logic                 st_valid_i,
  input  logic [ADDR_W-1:0]    st_addr_i,
  input  logic [2:0]           st_mtype_i,
  input  logic                 wait_consume_i,
  input  logic                 legacy_arm_i,
  output logic                 armed_o,
  output logic                 triggered_o,
  output logic                 fault_valid_o,
  output logic [2:0]           fault_code_o,
  output logic                 legacy_nosleep_o,
  output logic [LINE_LOG2:0]   range_bytes_o
);
  fault_e            req_fault;
  logic [ADDR_W-1:0] req_lin;
  logic              arm_ok;
  logic              range_hit;
  logic              st_wb_hit;
  logic [TAG_W-1:0]  mon_tag;
  mon_state_e        mon_state;
  logic              flt_v_q;
  fault_e            flt_c_q;

  umon_req_check #(
    .ADDR_W (ADDR_W),
    .VA_BITS(VA_BITS),
    .LIM_W  (32)
  ) u_check (
    .mode_i      (addr_mode_i),
    .ea_i        (eff_addr_i),
    .seg_base_i  (seg_base_i),
    .seg_limit_i (seg_limit_i),
    .seg_is_ss_i (seg_is_ss_i),
    .seg_null_i  (seg_null_i),
    .feat_en_i   (feat_en_i),
    .in_txn_i    (in_txn_i),
    .fault_o     (req_fault),
    .lin_o       (req_lin)
  );

  assign arm_ok = arm_req_i && (req_fault == FLT_NONE);

  umon_range #(
    .ADDR_W   (ADDR_W),
    .LINE_LOG2(LINE_LOG2)
  ) u_range (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (arm_ok),
    .lin_i     (req_lin),
    .st_addr_i (st_addr_i),
    .tag_o     (mon_tag),
    .hit_o     (range_hit)
  );

  assign st_wb_hit = st_valid_i && (st_mtype_i == MTYPE_WB) && range_hit;

  umon_fsm u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .arm_ok_i         (arm_ok),
    .st_hit_i         (st_wb_hit),
    .consume_i        (wait_consume_i),
    .legacy_arm_i     (legacy_arm_i),
    .state_o          (mon_state),
    .legacy_nosleep_o (legacy_nosleep_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_v_q <= 1'b0;
      flt_c_q <= FLT_NONE;
    end else begin
      flt_v_q <= arm_req_i && (req_fault != FLT_NONE);
      flt_c_q <= arm_req_i ? req_fault : FLT_NONE;
    end
  end

  assign armed_o       = (mon_state == MON_ARMED);
  assign triggered_o   = (mon_state == MON_TRIG);
  assign fault_valid_o = flt_v_q;
  assign fault_code_o  = flt_c_q;
  assign range_bytes_o = {1'b1, {LINE_LOG2{1'b0}}};
endmodule

// File: rtl/umon_unit_chk.sv
module umon_unit_chk #(
  parameter int ADDR_W    = 64,
  parameter int LINE_LOG2 = 6,
  localparam int TAG_W    = ADDR_W - LINE_LOG2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_req_i,
  input logic              feat_en_i,
  input logic              st_valid_i,
  input logic [ADDR_W-1:0] st_addr_i,
  input logic [2:0]        st_mtype_i,
  input logic              wait_consume_i,
  input logic              legacy_arm_i,
  input logic              armed_o,
  input logic              triggered_o,
  input logic              fault_valid_o,
  input logic [2:0]        fault_code_o,
  input logic              legacy_nosleep_o,
  input logic [TAG_W-1:0]  mon_tag
);
  logic unused_lo;
  logic in_rng;
  assign unused_lo = ^st_addr_i[LINE_LOG2-1:0];
  assign in_rng    = (st_addr_i[ADDR_W-1:LINE_LOG2] == mon_tag);

  // R1
  state_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({armed_o, triggered_o}));

  // R3
  wb_hit_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && st_valid_i && st_mtype_i == 3'd6 && in_rng && !arm_req_i && !wait_consume_i)
    |=> triggered_o);

  // R4
  non_wb_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && st_valid_i && st_mtype_i != 3'd6 && !arm_req_i && !wait_consume_i)
    |=> armed_o);

  // R5
  feat_off_ud_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_req_i && !feat_en_i) |=> (fault_valid_o && fault_code_o == 3'd1));

  // R11
  fault_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_req_i && !wait_consume_i) ##1 fault_valid_o
    |-> (armed_o == $past(armed_o) && triggered_o == $past(triggered_o)));

  // R11
  code_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_valid_o |-> fault_code_o == 3'd0);

  // R11
  fault_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_req_i |=> !fault_valid_o);

  // R12
  consume_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_consume_i && !arm_req_i) |=> (!armed_o && !triggered_o));

  // R13
  legacy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_arm_i && !arm_req_i) |=> !legacy_nosleep_o);
endmodule

bind umon_unit umon_unit_chk #(
  .ADDR_W   (ADDR_W),
  .LINE_LOG2(LINE_LOG2)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .arm_req_i        (arm_req_i),
  .feat_en_i        (feat_en_i),
  .st_valid_i       (st_valid_i),
  .st_addr_i        (st_addr_i),
  .st_mtype_i       (st_mtype_i),
  .wait_consume_i   (wait_consume_i),
  .legacy_arm_i     (legacy_arm_i),
  .armed_o          (armed_o),
  .triggered_o      (triggered_o),
  .fault_valid_o    (fault_valid_o),
  .fault_code_o     (fault_code_o),
  .legacy_nosleep_o (legacy_nosleep_o),
  .mon_tag          (mon_tag)
);

// File: tb/umon_unit_tb_top.sv
module umon_unit_tb_top;
  localparam int LL = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_req_i, seg_is_ss_i, seg_null_i, feat_en_i, in_txn_i;
  logic [1:0]  addr_mode_i;
  logic [63:0] eff_addr_i, seg_base_i, st_addr_i;
  logic [31:0] seg_limit_i;
  logic        st_valid_i, wait_consume_i, legacy_arm_i;
  logic [2:0]  st_mtype_i;
  logic        armed_o, triggered_o, fault_valid_o, legacy_nosleep_o;
  logic [2:0]  fault_code_o;
  logic [LL:0] range_bytes_o;

  umon_unit dut_i (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    int         due;
    logic       a, t, fv, l;
    logic [2:0] c;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;
  int         m_st = 0;
  logic [57:0] m_tag = '0;
  logic       m_leg = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, {59'd0, armed_o, triggered_o, fault_valid_o, legacy_nosleep_o, fault_code_o[0]},
                 {59'd0, e.a, e.t, e.fv, e.l, e.c[0]});
      chk(e.tag, {61'd0, fault_code_o}, {61'd0, e.c});
    end
  end

  function automatic logic [63:0] ea_w();
    case (addr_mode_i)
      2'd1:    return {48'd0, eff_addr_i[15:0]};
      2'd3:    return eff_addr_i;
      default: return {32'd0, eff_addr_i[31:0]};
    endcase
  endfunction

  function automatic logic [63:0] exp_lin();
    logic [31:0] s;
    if (addr_mode_i == 2'd3) return seg_base_i + eff_addr_i;
    s = seg_base_i[31:0] + ea_w();
    return {32'd0, s};
  endfunction

  function automatic logic [2:0] exp_fault();
    logic [63:0] l;
    logic [2:0]  sf;
    sf = seg_is_ss_i ? 3'd3 : 3'd2;
    if (!feat_en_i) return 3'd1;
    if (in_txn_i) return 3'd4;
    case (addr_mode_i)
      2'd0: if (ea_w() > 64'hFFFF) return sf;
      2'd3: begin
        l = exp_lin();
        if (!(l[63:47] == '0 || l[63:47] == '1)) return sf;
      end
      default: begin
        if (seg_null_i) return 3'd2;
        if (ea_w() > {32'd0, seg_limit_i}) return sf;
      end
    endcase
    return 3'd0;
  endfunction

  task automatic idle_inputs();
    arm_req_i = 0; addr_mode_i = 2'd3; eff_addr_i = '0; seg_base_i = '0;
    seg_limit_i = 32'hFFFF_FFFF; seg_is_ss_i = 0; seg_null_i = 0; feat_en_i = 1;
    in_txn_i = 0; st_valid_i = 0; st_addr_i = '0; st_mtype_i = 3'd6;
    wait_consume_i = 0; legacy_arm_i = 0;
  endtask

  // driver: inputs already set at a negedge; model the edge and queue result
  task automatic step(input string tag);
    exp_t       e;
    logic [2:0] f;
    logic       ok, hit;
    f   = arm_req_i ? exp_fault() : 3'd0;
    ok  = arm_req_i && f == 3'd0;
    hit = st_valid_i && st_mtype_i == 3'd6 && st_addr_i[63:LL] == m_tag;
    if (ok) begin m_st = 1; m_tag = exp_lin() >> LL; end
    else if (wait_consume_i) m_st = 0;
    else if (m_st == 1 && hit) m_st = 2;
    if (ok) m_leg = 1; else if (legacy_arm_i) m_leg = 0;
    e.due = cyc + 1; e.a = (m_st == 1); e.t = (m_st == 2);
    e.fv = arm_req_i && f != 3'd0; e.c = f; e.l = m_leg; e.tag = tag;
    q.push_back(e);
    @(negedge clk_i);
    idle_inputs();
  endtask

  task automatic arm64(input logic [63:0] ea, input string tag);
    arm_req_i = 1; addr_mode_i = 2'd3; eff_addr_i = ea; step(tag);
  endtask

  task automatic store(input logic [63:0] a, input logic [2:0] t, input string tag);
    st_valid_i = 1; st_addr_i = a; st_mtype_i = t; step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 reset", {60'd0, armed_o, triggered_o, fault_valid_o, legacy_nosleep_o}, 64'd0);
    chk("R11 reset code", {61'd0, fault_code_o}, 64'd0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R2 range size", {57'd0, range_bytes_o}, 64'd64);

    arm64(64'h1000_1234, "R1 arm 64-bit");
    store(64'h1000_1240, 3'd6, "R2 store above range");
    store(64'h1000_11FF, 3'd6, "R2 store below range");
    store(64'h1000_1210, 3'd0, "R4 uncached store in range");
    store(64'h1000_1210, 3'd4, "R4 other type in range");
    store(64'h1000_123F, 3'd6, "R3 wb store last byte");
    wait_consume_i = 1; step("R12 consume to idle");
    store(64'h1000_1200, 3'd6, "R3 store while idle");

    feat_en_i = 0; arm_req_i = 1; eff_addr_i = 64'h40; step("R5 feature off");
    arm64(64'h2000, "R1 rearm");
    feat_en_i = 0; arm_req_i = 1; step("R11 fault keeps armed");
    step("R11 fault pulse ends");
    in_txn_i = 1; arm_req_i = 1; eff_addr_i = 64'h3000; step("R6 txn abort");
    in_txn_i = 1; feat_en_i = 0; arm_req_i = 1; step("R5 priority over txn");

    arm64(64'h0000_8000_0000_0000, "R7 noncanonical gp");
    seg_is_ss_i = 1; arm64(64'h0000_8000_0000_0000, "R7 noncanonical ss");
    seg_base_i = 64'h0000_7FFF_FFFF_FFC0; arm64(64'h40, "R7 base pushes noncanonical");
    arm64(64'hFFFF_8000_0000_0100, "R7 canonical high arms");
    store(64'hFFFF_8000_0000_0120, 3'd6, "R7 trigger at high range");

    arm_req_i = 1; addr_mode_i = 2'd0; eff_addr_i = 64'h1_0000; step("R8 real gp");
    arm_req_i = 1; addr_mode_i = 2'd0; eff_addr_i = 64'h1_0000; seg_is_ss_i = 1; step("R8 real ss");
    arm_req_i = 1; addr_mode_i = 2'd0; eff_addr_i = 64'hFFFF_FFFF_0000_FFFF;
    seg_base_i = 64'h1230; step("R10 real upper bits ignored");
    store(64'h0001_122F, 3'd6, "R10 real linear trigger");

    arm_req_i = 1; addr_mode_i = 2'd1; eff_addr_i = 64'hABCD_0000_0000_0010;
    seg_base_i = 64'h2000; seg_limit_i = 32'hFFFF; step("R10 p16 truncation arms");
    store(64'h2030, 3'd6, "R10 p16 trigger");
    arm_req_i = 1; addr_mode_i = 2'd2; eff_addr_i = 64'h1_0000; seg_limit_i = 32'hFFFF; step("R9 limit gp");
    arm_req_i = 1; addr_mode_i = 2'd2; eff_addr_i = 64'h1_0000; seg_limit_i = 32'hFFFF;
    seg_is_ss_i = 1; step("R9 limit ss");
    arm_req_i = 1; addr_mode_i = 2'd2; eff_addr_i = 64'h10; seg_null_i = 1; seg_is_ss_i = 1; step("R9 null gp");
    arm_req_i = 1; addr_mode_i = 2'd2; eff_addr_i = 64'hFFFF; seg_limit_i = 32'hFFFF;
    seg_base_i = 64'hFFFF_FFFF_FFFF_0000; step("R10 p32 wrap at limit arms");
    store(64'h0000_0000_FFFF_FFC0, 3'd6, "R10 p32 wrapped trigger");

    legacy_arm_i = 1; step("R13 legacy arm clears");
    feat_en_i = 0; arm_req_i = 1; step("R13 faulting arm keeps clear");
    legacy_arm_i = 1; arm64(64'h5000, "R13 same-cycle user wins");
    store(64'h5000, 3'd6, "R3 trigger before rearm");
    store(64'h5008, 3'd6, "R3 stays triggered");
    st_valid_i = 1; st_addr_i = 64'h6000; st_mtype_i = 3'd6; arm64(64'h7000, "R12 arm beats store");
    wait_consume_i = 1; arm64(64'h6000, "R12 arm beats consume");
    store(64'h7000, 3'd6, "R1 old range replaced");
    store(64'h6010, 3'd6, "R1 new range triggers");
    @(negedge clk_i);
    chk("R1 scoreboard drained", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule